// File: doc/BRIEF.md
# Paged 32-bit Switch Register Bridge

This block carries 32-bit register accesses aimed at an Ethernet switch across a management bus that only moves 16 bits per transaction. The switch's register space is paged. Each request therefore turns into three management transactions. The first writes a page number. The next two move the two 16-bit halves of the register, using a PHY address and a register number that are derived from the switch register address.

The request side uses a valid/ready handshake and takes a write flag, a register address, 32 bits of write data and a model select. The model select chooses between two conventions for where the page number is written. A response pulse returns either an error flag or the assembled read data. On the management side the block issues one transaction at a time and waits for a neighbouring controller to report that it is complete. That controller does the bit-level framing and reports a completion strobe, an error flag and the 16 bits it read. Any transaction that reports an error ends the whole access at once.

Top module: `swreg_bridge`

## Requirements
- R1: The first transaction of every access is a write whose 16-bit data is the request address shifted right by 9 (low 16 bits of that value).
- R2: The page write goes to PHY 0x1F, register 0x10 when model_b=0, and to PHY 0x18, register 0x00 when model_b=1.
- R3: Both half transactions use PHY address 0x10 OR'ed with address bits [8:6].
- R4: The low half uses register number {addr[5:2],0} and the high half uses {addr[5:2],1}.
- R5: A read fetches the low half before the high half. On success, rsp_rdata = {high,low}. rsp_rdata is zero for writes and for failed accesses.
- R6: A write normally sends the high half (wdata[31:16]) first and then the low half (wdata[15:0]).
- R7: With model_b=0 and address 0x98, a write sends the low half first. With model_b=1, address 0x98 follows R6.
- R8: req_ready is low from the cycle after acceptance until the response. rsp_valid is a one-cycle pulse in the cycle after the final completion. req_ready is high again in the following cycle.
- R9: A completion with mdio_err set ends the access. No further transaction is issued, and the response carries rsp_err=1.
- R10: mdio_cmd_valid is a one-cycle pulse, and the next pulse comes only after mdio_done for the previous one.
- R11: After reset, req_ready=1, mdio_cmd_valid=0 and rsp_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_model_b | input | 1 | Page convention select (0 = A, 1 = B) |
| req_addr | input | ADDR_W | Switch register address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Access aborted by a transaction error |
| rsp_rdata | output | 32 | Assembled read data |
| mdio_cmd_valid | output | 1 | Start one management transaction |
| mdio_cmd_write | output | 1 | Transaction is a write |
| mdio_cmd_phy | output | 5 | Target PHY address |
| mdio_cmd_reg | output | 5 | Target register number |
| mdio_cmd_wdata | output | 16 | Write data of the transaction |
| mdio_done | input | 1 | Transaction complete (one cycle) |
| mdio_err | input | 1 | Completed transaction failed |
| mdio_rdata | input | 16 | Data read by the transaction |

## Verification
Reads are tried under both models, at a low address and at an address with every page, PHY and register field non-zero. Because each read half returns data that encodes its own PHY and register, a swapped half or a wrong field shows up in the assembled word. Writes go to address 0x98 under each model and to 0x40 under model A, which separates the reversed ordering from the normal one. Errors injected on the page write and on a data half show that the access stops at the failing transaction. The completion latency is also varied so that ready and pulse timing are not tied to one delay.

// File: rtl/swb_pkg.sv
package swb_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESP} swb_state_e;

  // PHY address that receives the page number
  function automatic logic [4:0] swb_page_phy(input logic model_b);
    return model_b ? 5'h18 : 5'h1F;
  endfunction

  // register number that receives the page number
  function automatic logic [4:0] swb_page_reg(input logic model_b);
    return model_b ? 5'h00 : 5'h10;
  endfunction

  function automatic logic [15:0] swb_page_value(input logic [31:0] a);
    logic [31:0] t;
    t = a >> 9;
    return t[15:0];
  endfunction

  function automatic logic [4:0] swb_half_phy(input logic [31:0] a);
    logic [31:0] t;
    t = ((a >> 6) & 32'h7) | 32'h10;
    return t[4:0];
  endfunction

  function automatic logic [4:0] swb_half_reg(input logic [31:0] a, input logic hi);
    logic [31:0] t;
    t = ((a >> 1) & 32'h1E) | {31'd0, hi};
    return t[4:0];
  endfunction

  // register whose write halves must go low first
  function automatic logic swb_low_first(input logic model_b, input logic [31:0] a);
    return !model_b && (a == 32'h98);
  endfunction

endpackage

// File: rtl/swb_addr_map.sv
module swb_addr_map
  import swb_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              model_b,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        step,
  output logic              cmd_write,
  output logic [4:0]        cmd_phy,
  output logic [4:0]        cmd_reg,
  output logic [HALF_W-1:0] cmd_wdata,
  output logic              half_hi
);
  logic [31:0] a32;
  logic        page_step;

  assign a32       = 32'(addr);
  assign page_step = (step == 2'd0);
  // step 2 is the high half for reads; writes flip that unless low-first
  assign half_hi   = (step == 2'd2) ^ (is_write && !swb_low_first(model_b, a32));

  always_comb begin
    if (page_step) begin
      cmd_write = 1'b1;
      cmd_phy   = swb_page_phy(model_b);
      cmd_reg   = swb_page_reg(model_b);
      cmd_wdata = HALF_W'(swb_page_value(a32));
    end else begin
      cmd_write = is_write;
      cmd_phy   = swb_half_phy(a32);
      cmd_reg   = swb_half_reg(a32, half_hi);
      cmd_wdata = half_hi ? wdata[DATA_W-1:HALF_W] : wdata[HALF_W-1:0];
    end
  end
endmodule

// File: rtl/swb_seq.sv
module swb_seq
  import swb_pkg::*;
#(
  parameter int STEPS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       mdio_done,
  input  logic       mdio_err,
  output logic       req_ready,
  output logic       accept,
  output logic       cmd_valid,
  output logic [1:0] step,
  output logic       half_done,
  output logic       rsp_valid,
  output logic       rsp_err
);
  localparam logic [1:0] LAST_STEP = 2'(STEPS - 1);

  swb_state_e state_q;
  logic [1:0] step_q;
  logic       err_q;
  logic       fail_evt;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign cmd_valid = (state_q == ST_ISSUE);
  assign half_done = (state_q == ST_WAIT) && mdio_done;
  assign fail_evt  = half_done && mdio_err;
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_err   = rsp_valid && err_q;
  assign step      = step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= 2'd0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_ISSUE;
          step_q  <= 2'd0;
          err_q   <= 1'b0;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (half_done) begin
          if (mdio_err) begin
            err_q   <= 1'b1;
            state_q <= ST_RESP;
          end else if (step_q == LAST_STEP) begin
            state_q <= ST_RESP;
          end else begin
            step_q  <= step_q + 2'd1;
            state_q <= ST_ISSUE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
  p_rsp_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mdio_done));
  p_single_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  p_err_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> (rsp_err && !cmd_valid));
endmodule

// File: rtl/swb_assemble.sv
module swb_assemble #(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture,
  input  logic                half_hi,
  input  logic [HALF_W-1:0]   half_in,
  output logic [2*HALF_W-1:0] word
);
  logic [HALF_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (capture) begin
      if (half_hi) hi_q <= half_in;
      else         lo_q <= half_in;
    end
  end

  assign word = {hi_q, lo_q};

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(word));
endmodule

// File: rtl/swreg_bridge.sv
module swreg_bridge #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_model_b,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              mdio_cmd_valid,
  output logic              mdio_cmd_write,
  output logic [4:0]        mdio_cmd_phy,
  output logic [4:0]        mdio_cmd_reg,
  output logic [15:0]       mdio_cmd_wdata,
  input  logic              mdio_done,
  input  logic              mdio_err,
  input  logic [15:0]       mdio_rdata
);
  localparam int DATA_W = 32;
  localparam int HALF_W = DATA_W / 2;
  localparam int STEPS  = 3;

  logic              accept, half_done, half_hi, capture;
  logic [1:0]        step;
  logic              wr_q, model_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      model_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      model_q <= req_model_b;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  swb_seq #(.STEPS(STEPS)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .mdio_done(mdio_done), .mdio_err(mdio_err),
    .req_ready(req_ready), .accept(accept), .cmd_valid(mdio_cmd_valid),
    .step(step), .half_done(half_done),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err)
  );

  swb_addr_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_map (
    .model_b(model_q), .is_write(wr_q), .addr(addr_q), .wdata(wdata_q),
    .step(step), .cmd_write(mdio_cmd_write), .cmd_phy(mdio_cmd_phy),
    .cmd_reg(mdio_cmd_reg), .cmd_wdata(mdio_cmd_wdata), .half_hi(half_hi)
  );

  assign capture = half_done && !mdio_err && !wr_q && (step != 2'd0);

  swb_assemble #(.HALF_W(HALF_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .capture(capture), .half_hi(half_hi),
    .half_in(mdio_rdata), .word(word)
  );

  assign rsp_rdata = (rsp_valid && !rsp_err && !wr_q) ? word : '0;

  p_page_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mdio_cmd_valid && mdio_cmd_write));
  p_no_data_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && wr_q) |-> (rsp_rdata == '0));
endmodule

// File: tb/swreg_bridge_tb.sv
module swreg_bridge_tb;
  localparam int ADDR_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              req_valid = 1'b0, req_write = 1'b0, req_model_b = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              req_ready, rsp_valid, rsp_err;
  logic [31:0]       rsp_rdata;
  logic              mdio_cmd_valid, mdio_cmd_write;
  logic [4:0]        mdio_cmd_phy, mdio_cmd_reg;
  logic [15:0]       mdio_cmd_wdata;
  logic              mdio_done = 1'b0, mdio_err = 1'b0;
  logic [15:0]       mdio_rdata = '0;

  swreg_bridge #(.ADDR_W(ADDR_W)) u_dut (.*);

  int errors = 0, checks = 0;

  // management-side responder and command log
  int          lat = 2, err_at = 9, cnt = 0, log_n = 0, overlap = 0;
  logic        lg_wr  [0:7];
  logic [4:0]  lg_phy [0:7];
  logic [4:0]  lg_reg [0:7];
  logic [15:0] lg_wd  [0:7];

  function automatic logic [15:0] rd_pattern(input logic [4:0] p, input logic [4:0] r);
    return {1'b1, p, r, 5'h0A};
  endfunction

  always @(negedge clk) begin
    mdio_done = 1'b0;
    mdio_err  = 1'b0;
    if (cnt > 0) begin
      cnt = cnt - 1;
      if (cnt == 0) begin
        mdio_done  = 1'b1;
        mdio_err   = ((log_n - 1) == err_at);
        mdio_rdata = rd_pattern(lg_phy[log_n-1], lg_reg[log_n-1]);
      end
    end
    if (mdio_cmd_valid) begin
      if (cnt > 0 || mdio_done) overlap = overlap + 1;
      if (log_n < 8) begin
        lg_wr[log_n]  = mdio_cmd_write;
        lg_phy[log_n] = mdio_cmd_phy;
        lg_reg[log_n] = mdio_cmd_reg;
        lg_wd[log_n]  = mdio_cmd_wdata;
      end
      log_n = log_n + 1;
      cnt = lat;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // runs one access and checks every transaction and the response
  task automatic run_req(input bit model, input bit wr, input logic [ADDR_W-1:0] a,
                         input logic [31:0] wd, input int e_at, input int latency);
    int          waited;
    bit          busy_ok;
    logic        got_err;
    logic [31:0] got_rd;
    int          exp_n;
    logic [4:0]  hphy, lo_r, hi_r, e_phy, e_reg;
    logic [15:0] e_wd;
    bit          lowfirst, is_hi;
    @(negedge clk);
    lat = latency; err_at = e_at; log_n = 0; overlap = 0;
    req_valid = 1'b1; req_write = wr; req_model_b = model; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    busy_ok = 1'b1; waited = 0;
    while (!rsp_valid && waited < 200) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
      waited++;
    end
    chk(rsp_valid, "R8 response arrives", rsp_valid, 1);
    chk(busy_ok, "R8 ready low while busy", !busy_ok, 0);
    got_err = rsp_err; got_rd = rsp_rdata;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R8 one-cycle pulse then ready", {rsp_valid, req_ready}, 2'b01);
    chk(overlap == 0, "R10 one transaction at a time", overlap, 0);

    exp_n = (e_at < 3) ? e_at + 1 : 3;
    chk(log_n == exp_n, (e_at < 3) ? "R9 count after abort" : "R1 three transactions", log_n, exp_n);
    chk(got_err == (e_at < 3), "R9 error flag", got_err, e_at < 3);

    hphy = {2'b10, a[8:6]};
    lo_r = {a[5:2], 1'b0};
    hi_r = {a[5:2], 1'b1};
    lowfirst = !model && (a == 24'h98);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      if (i == 0) begin
        chk(lg_wr[0] == 1'b1, "R1 page is a write", lg_wr[0], 1);
        chk(lg_wd[0] == 16'(a >> 9), "R1 page value", lg_wd[0], 16'(a >> 9));
        e_phy = model ? 5'h18 : 5'h1F;
        e_reg = model ? 5'h00 : 5'h10;
        chk(lg_phy[0] == e_phy, "R2 page PHY", lg_phy[0], e_phy);
        chk(lg_reg[0] == e_reg, "R2 page register", lg_reg[0], e_reg);
      end else begin
        if (!wr) is_hi = (i == 2);
        else     is_hi = lowfirst ? (i == 2) : (i == 1);
        e_reg = is_hi ? hi_r : lo_r;
        chk(lg_phy[i] == hphy, "R3 half PHY", lg_phy[i], hphy);
        chk(lg_wr[i] == wr, "R5 R6 half direction", lg_wr[i], wr);
        chk(lg_reg[i] == e_reg, wr ? (lowfirst ? "R7 low-first order" : "R6 high-first order")
                                   : "R4 R5 read half order", lg_reg[i], e_reg);
        if (wr) begin
          e_wd = is_hi ? wd[31:16] : wd[15:0];
          chk(lg_wd[i] == e_wd, "R6 R7 half data", lg_wd[i], e_wd);
        end
      end
    end
    if (!wr && e_at >= 3)
      chk(got_rd == {rd_pattern(hphy, hi_r), rd_pattern(hphy, lo_r)}, "R5 assembled word",
          got_rd, {rd_pattern(hphy, hi_r), rd_pattern(hphy, lo_r)});
    else
      chk(got_rd == 32'h0, "R5 no read data", got_rd, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 ready after reset", req_ready, 1);
    chk(mdio_cmd_valid == 1'b0, "R11 no command after reset", mdio_cmd_valid, 0);
    chk(rsp_valid == 1'b0, "R11 no response after reset", rsp_valid, 0);
  endtask

  task automatic t_read_a_low();   run_req(1'b0, 1'b0, 24'h00000C, 32'h0, 9, 2);      endtask
  task automatic t_read_b_wide();  run_req(1'b1, 1'b0, 24'h0ABDEC, 32'h0, 9, 3);      endtask
  task automatic t_write_a_98();   run_req(1'b0, 1'b1, 24'h000098, 32'hCAFE1234, 9, 1); endtask
  task automatic t_write_b_98();   run_req(1'b1, 1'b1, 24'h000098, 32'h89AB4567, 9, 2); endtask
  task automatic t_write_a_40();   run_req(1'b0, 1'b1, 24'h012E40, 32'h5A5AA5A5, 9, 2); endtask
  task automatic t_err_page();     run_req(1'b0, 1'b0, 24'h00010C, 32'h0, 0, 2);      endtask
  task automatic t_err_half();     run_req(1'b1, 1'b1, 24'h0007FC, 32'h11112222, 1, 1); endtask
  task automatic t_read_after_err(); run_req(1'b0, 1'b0, 24'h03FFFC, 32'h0, 9, 1);    endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read_a_low();
    t_read_b_wide();
    t_write_a_98();
    t_write_b_98();
    t_write_a_40();
    t_err_page();
    t_err_half();
    t_read_after_err();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule